// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block keeps the interrupt status word of an SD host controller. The controller core reports single-cycle event pulses: command done, transfer done, card inserted, card removed, and eight separate error causes. Each pulse is latched into its own status bit, but only when the matching bit of a recording mask is set. A second mask, the signalling mask, picks which latched bits drive the single interrupt line. A read-only summary bit shows whether any error cause is latched.

Software uses a small register port with an address, write data, a write strobe and a read strobe. Writing a one to a status bit clears that bit, and writing a zero leaves it unchanged. Card insertion and removal pulses are checked against the live card-present level before they are latched, so a bouncing contact does not leave a wrong event behind. The live level can also be read.

The word map is fixed and is addressed by word. Word 0 is the status word. Word 1 is the recording mask. Word 2 is the signalling mask. Word 3 holds the card-present level in bit 0. Every other address reads as zero.

Top module: `sd_irq_status`

## Requirements
- R1: While reset is high, the status word, both masks, the read data and the interrupt output are all cleared to zero on each clock edge.
- R2: An event pulse sets its status bit on the clock edge where it is high only if the matching recording-mask bit is set. The status bit positions are: bit 0 command done, bit 1 transfer done, bit 6 card inserted, bit 7 card removed, and bits 16 to 23 for error causes 0 to 7.
- R3: A write to word 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: If an event pulse that is being recorded and a clearing write reach the same status bit on the same edge, the bit ends up set.
- R5: A card-inserted pulse is recorded only while the card-present input is high. A card-removed pulse is recorded only while it is low. Word 3 bit 0 reads back the live card-present level.
- R6: Status bit 15 is read-only. It is 1 exactly when any of status bits 16 to 23 is set, and writes to it have no effect.
- R7: The interrupt output goes high one clock edge after any status bit, including bit 15, is set together with its signalling-mask bit. An error cause that is recorded but not enabled for signalling does not raise the interrupt.
- R8: When both masks are zero, no event is recorded and the interrupt output stays low.
- R9: Only the bit positions listed in R2, plus bit 15 in the signalling mask, are implemented. All other bits read as zero. After all ones are written, the recording mask reads 0x00FF00C3 and the signalling mask reads 0x00FF80C3, so no word ever reads as all ones.
- R10: Read data is updated on the edge where the read strobe is high and holds its value otherwise. A read of any address above 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_cmd_done | input | 1 | Command-done pulse |
| evt_xfer_done | input | 1 | Transfer-done pulse |
| evt_card_in | input | 1 | Card-inserted pulse |
| evt_card_out | input | 1 | Card-removed pulse |
| evt_err | input | ERR_N | Error-cause pulses |
| card_present | input | 1 | Live card-present level |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an event pulse and a clearing write hitting the same status bit on the same edge. The bench drives the event input and the write strobe together on one falling edge, once with the bit already set and once with it clear, and then reads the word back. The card-qualification rule needs its own stimulus: the bench sends insert and remove pulses at both card-present levels and checks that only the pulse that agrees with the level is recorded. The bench walks a vector table of mask and event combinations. Some rows enable error causes for recording only and confirm that the interrupt stays low until the summary bit is enabled for signalling.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

    localparam int REG_W    = 32;
    localparam int ERR_N    = 8;

    localparam int B_CMD    = 0;
    localparam int B_XFER   = 1;
    localparam int B_INS    = 6;
    localparam int B_REM    = 7;
    localparam int B_ERRSUM = 15;
    localparam int B_ERR0   = 16;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_REC_EN  = 2'd1,
        SEL_SIG_EN  = 2'd2,
        SEL_PRESENT = 2'd3
    } sel_e;

    typedef struct packed {
        logic [ERR_N-1:0] err;
        logic             card_out;
        logic             card_in;
        logic             xfer;
        logic             cmd;
    } evt_t;

    function automatic logic [REG_W-1:0] build_evt_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[B_CMD]  = 1'b1;
        m[B_XFER] = 1'b1;
        m[B_INS]  = 1'b1;
        m[B_REM]  = 1'b1;
        for (int i = 0; i < ERR_N; i++) m[B_ERR0+i] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] EVT_MASK = build_evt_mask();
    localparam logic [REG_W-1:0] SIG_MASK = build_evt_mask() | (REG_W'(1) << B_ERRSUM);

    // Map event pulses onto status positions, qualifying card events by level
    function automatic logic [REG_W-1:0] place_events(evt_t e, logic present);
        logic [REG_W-1:0] v;
        v = '0;
        v[B_CMD]  = e.cmd;
        v[B_XFER] = e.xfer;
        v[B_INS]  = e.card_in & present;
        v[B_REM]  = e.card_out & ~present;
        for (int i = 0; i < ERR_N; i++) v[B_ERR0+i] = e.err[i];
        return v;
    endfunction

    // Software-visible status: implemented latches plus the error summary
    function automatic logic [REG_W-1:0] with_summary(logic [REG_W-1:0] s);
        logic [REG_W-1:0] r;
        r = s & EVT_MASK;
        r[B_ERRSUM] = |s[B_ERR0 +: ERR_N];
        return r;
    endfunction

endpackage

// File: rtl/sd_irq_latch.sv
module sd_irq_latch
#(
    parameter int W = 32
)
(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);

    // One sticky bit per position; a set on the same edge beats a clear
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else
                q[i] <= (q[i] & ~clr_vec[i]) | set_vec[i];
        end
    end

endmodule

// File: rtl/sd_irq_regfile.sv
module sd_irq_regfile
    import sd_irq_pkg::*;
#(
    parameter int ADDR_W = 4
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  status_view,
    input  logic              present,
    output logic [REG_W-1:0]  rec_en,
    output logic [REG_W-1:0]  sig_en,
    output logic [REG_W-1:0]  clr_vec,
    output logic [REG_W-1:0]  rdata
);

    logic hit;
    sel_e sel;

    assign hit = (32'(addr) < 32'd4);
    assign sel = sel_e'(addr[1:0]);

    assign clr_vec = (wr_en && hit && sel == SEL_STATUS) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_en <= '0;
            sig_en <= '0;
        end else if (wr_en && hit) begin
            if (sel == SEL_REC_EN) rec_en <= wdata & EVT_MASK;
            if (sel == SEL_SIG_EN) sig_en <= wdata & SIG_MASK;
        end
    end

    logic [REG_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (hit) begin
            case (sel)
                SEL_STATUS:  rd_mux = status_view;
                SEL_REC_EN:  rd_mux = rec_en;
                SEL_SIG_EN:  rd_mux = sig_en;
                SEL_PRESENT: rd_mux = {{(REG_W-1){1'b0}}, present};
                default:     rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/sd_irq_signal.sv
module sd_irq_signal
    import sd_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] status_view,
    input  logic [REG_W-1:0] sig_en,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= |(status_view & sig_en);
    end

endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status
    import sd_irq_pkg::*;
#(
    parameter int ADDR_W = 4
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              evt_cmd_done,
    input  logic              evt_xfer_done,
    input  logic              evt_card_in,
    input  logic              evt_card_out,
    input  logic [ERR_N-1:0]  evt_err,
    input  logic              card_present,
    output logic              irq
);

    evt_t             evt;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] status_lat;
    logic [REG_W-1:0] status_view;
    logic [REG_W-1:0] rec_en;
    logic [REG_W-1:0] sig_en;

    assign evt.cmd      = evt_cmd_done;
    assign evt.xfer     = evt_xfer_done;
    assign evt.card_in  = evt_card_in;
    assign evt.card_out = evt_card_out;
    assign evt.err      = evt_err;

    assign set_vec     = place_events(evt, card_present) & rec_en;
    assign status_view = with_summary(status_lat);

    sd_irq_latch #(.W(REG_W)) i_latch (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (status_lat)
    );

    sd_irq_regfile #(.ADDR_W(ADDR_W)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .status_view (status_view),
        .present     (card_present),
        .rec_en      (rec_en),
        .sig_en      (sig_en),
        .clr_vec     (clr_vec),
        .rdata       (rdata)
    );

    sd_irq_signal i_sig (
        .clk         (clk),
        .rst         (rst),
        .status_view (status_view),
        .sig_en      (sig_en),
        .irq         (irq)
    );

endmodule

// File: rtl/sd_irq_checker.sv
module sd_irq_checker
#(
    parameter int ADDR_W = 4
)
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic              evt_cmd_done,
    input logic              card_present,
    input logic              rec_en_cmd,
    input logic              stat_cmd,
    input logic              stat_ins,
    input logic [31:0]       status_view,
    input logic [31:0]       sig_en
);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (rdata == 32'd0 && !irq && status_view == 32'd0 && sig_en == 32'd0));

    // R2
    a_r2_no_record: assert property (@(posedge clk) disable iff (rst)
        (!rec_en_cmd && !stat_cmd) |=> !stat_cmd);

    // R4
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (evt_cmd_done && rec_en_cmd) |=> stat_cmd);

    // R5
    a_r5_insert_qualified: assert property (@(posedge clk) disable iff (rst)
        (!card_present && !stat_ins) |=> !stat_ins);

    // R6
    a_r6_summary_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == '0) |=> (rdata[15] == |rdata[23:16]));

    // R7
    a_r7_irq_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(status_view & sig_en))));

    // R9
    a_r9_never_all_ones: assert property (@(posedge clk) disable iff (rst)
        rdata != 32'hFFFF_FFFF);

endmodule

bind sd_irq_status sd_irq_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (rd_en),
    .addr         (addr),
    .rdata        (rdata),
    .irq          (irq),
    .evt_cmd_done (evt_cmd_done),
    .card_present (card_present),
    .rec_en_cmd   (rec_en[0]),
    .stat_cmd     (status_lat[0]),
    .stat_ins     (status_lat[6]),
    .status_view  (status_view),
    .sig_en       (sig_en)
);

// File: tb/test_sd_irq_status.sv
module test_sd_irq_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt_cmd_done = 1'b0;
    logic        evt_xfer_done = 1'b0;
    logic        evt_card_in = 1'b0;
    logic        evt_card_out = 1'b0;
    logic [7:0]  evt_err = '0;
    logic        card_present = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sd_irq_status #(.ADDR_W(4)) i_sd_irq_status (
        .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .evt_cmd_done (evt_cmd_done), .evt_xfer_done (evt_xfer_done),
        .evt_card_in (evt_card_in), .evt_card_out (evt_card_out),
        .evt_err (evt_err), .card_present (card_present), .irq (irq)
    );

    typedef struct packed {
        logic [31:0] rec;
        logic [31:0] sig;
        logic [11:0] ev;
        logic        pres;
    } vec_t;

    // ev bits: 0 cmd, 1 xfer, 2 insert, 3 remove, 11:4 error causes 0..7
    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{32'hFFFF_FFFF, 32'h0000_0001, 12'h001, 1'b0},
        '{32'h00FF_0003, 32'h0000_0001, 12'h090, 1'b0},
        '{32'h00FF_0003, 32'h0000_8000, 12'h090, 1'b0},
        '{32'h0000_0002, 32'hFFFF_FFFF, 12'h003, 1'b0},
        '{32'h0000_0040, 32'h0000_0040, 12'h004, 1'b0},
        '{32'h0000_0040, 32'h0000_0040, 12'h004, 1'b1},
        '{32'h0000_0080, 32'h0000_0080, 12'h008, 1'b1},
        '{32'h0000_0080, 32'h0000_0080, 12'h008, 1'b0},
        '{32'h0000_0000, 32'hFFFF_FFFF, 12'hFFF, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0000, 12'hFFF, 1'b1}
    };

    function automatic logic [31:0] exp_status(logic [31:0] rec, logic [11:0] ev, logic pres);
        logic [31:0] s;
        s = '0;
        s[0] = ev[0] & rec[0];
        s[1] = ev[1] & rec[1];
        s[6] = ev[2] & rec[6] & pres;
        s[7] = ev[3] & rec[7] & ~pres;
        for (int i = 0; i < 8; i++) s[16+i] = ev[4+i] & rec[16+i];
        s[15] = |s[23:16];
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive_ev(input logic [11:0] ev);
        evt_cmd_done = ev[0]; evt_xfer_done = ev[1];
        evt_card_in = ev[2]; evt_card_out = ev[3];
        evt_err = ev[11:4];
    endtask

    task automatic pulse(input logic [11:0] ev);
        @(negedge clk);
        drive_ev(ev);
        @(negedge clk);
        drive_ev(12'h000);
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] s;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 rdata", rdata, 32'd0);
        do_read(4'd0, d); check("R1 status", d, 32'd0);
        do_read(4'd1, d); check("R1 rec mask", d, 32'd0);
        do_read(4'd2, d); check("R1 sig mask", d, 32'd0);

        // Vector table: R2 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            do_write(4'd0, 32'hFFFF_FFFF);
            do_write(4'd1, TBL[i].rec);
            do_write(4'd2, TBL[i].sig);
            card_present = TBL[i].pres;
            pulse(TBL[i].ev);
            do_read(4'd0, d);
            s = exp_status(TBL[i].rec, TBL[i].ev, TBL[i].pres);
            check($sformatf("R2/R5/R8 status vec %0d", i), d, s);
            check($sformatf("R7 irq vec %0d", i), {31'b0, irq},
                  {31'b0, |(s & TBL[i].sig & 32'h00FF_80C3)});
        end

        // R9 implemented bits only
        do_write(4'd1, 32'hFFFF_FFFF);
        do_write(4'd2, 32'hFFFF_FFFF);
        do_read(4'd1, d); check("R9 rec mask", d, 32'h00FF_00C3);
        do_read(4'd2, d); check("R9 sig mask", d, 32'h00FF_80C3);
        do_write(4'd0, 32'hFFFF_FFFF);
        card_present = 1'b1;
        pulse(12'hFFF);
        do_read(4'd0, d); check("R9 full status", d, 32'h00FF_8043);

        // R5 live level readback
        do_read(4'd3, d); check("R5 present high", d, 32'd1);
        card_present = 1'b0;
        do_read(4'd3, d); check("R5 present low", d, 32'd0);

        // R10 unmapped address and hold
        do_read(4'd5, d); check("R10 unmapped", d, 32'd0);
        do_read(4'd0, d);
        do_write(4'd0, 32'h0000_0003);
        repeat (2) @(negedge clk);
        check("R10 hold", rdata, 32'h00FF_8043);

        // R3 write-one-to-clear
        do_write(4'd0, 32'h0000_0000);
        do_read(4'd0, d); check("R3 zero write", d, 32'h00FF_8040);
        do_write(4'd0, 32'h00FE_0040);
        do_read(4'd0, d); check("R3 partial clear", d, 32'h0001_8000);

        // R6 summary read-only
        do_write(4'd0, 32'h0000_8000);
        do_read(4'd0, d); check("R6 summary not cleared", d, 32'h0001_8000);
        do_write(4'd0, 32'h0001_0000);
        do_read(4'd0, d); check("R6 summary drops", d, 32'h0000_0000);

        // R4 set wins over clear, bit already set and bit clear
        pulse(12'h001);
        @(negedge clk);
        drive_ev(12'h001); wr_en = 1'b1; addr = 4'd0; wdata = 32'h0000_0001;
        @(negedge clk);
        drive_ev(12'h000); wr_en = 1'b0;
        do_read(4'd0, d); check("R4 set while set", d, 32'h0000_0001);
        do_write(4'd0, 32'h0000_0001);
        @(negedge clk);
        drive_ev(12'h002); wr_en = 1'b1; addr = 4'd0; wdata = 32'h0000_0002;
        @(negedge clk);
        drive_ev(12'h000); wr_en = 1'b0;
        do_read(4'd0, d); check("R4 set while clear", d, 32'h0000_0002);

        // R8 masks zeroed
        do_write(4'd1, 32'h0);
        do_write(4'd2, 32'h0);
        @(negedge clk);
        check("R8 irq after sig off", {31'b0, irq}, 32'd0);
        do_write(4'd0, 32'hFFFF_FFFF);
        pulse(12'hFFF);
        do_read(4'd0, d); check("R8 nothing recorded", d, 32'd0);

        // R1 reset mid-run
        do_write(4'd1, 32'hFFFF_FFFF);
        do_write(4'd2, 32'hFFFF_FFFF);
        pulse(12'h001);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {31'b0, irq}, 32'd0);
        do_read(4'd0, d); check("R1 status after reset", d, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule